// File: doc/BRIEF.md
# Multi-Key Debouncer with Shared Timer

This block debounces a small group of active-low key inputs with a single counter shared by all of them. The counter advances on a slow debounce tick, which is a one-cycle enable in the system clock domain. A level change on any key, once synchronized, starts the counter from zero for that key. A further change on the same key before the window ends cancels the debounce. A change on a different key restarts the window for that key.

When the window completes, the selected key's stored status is compared with its current level. If the two differ, the status bit takes the new level (pressed = 1) and a level interrupt is raised. Software clears the interrupt with a status-read strobe or an explicit clear command. Two busy outputs, a supply-output enable and a clock-on flag, are high while the counter runs. The whole function works only while the active-mode input is high.

Top module: `multikey_debounce`

## Requirements
- R1: While `active_en` is low, key changes start nothing and a running window is abandoned: both busy outputs are low one cycle after `active_en` is sampled low, and neither status nor interrupt changes.
- R2: With the counter idle, a key change starts a window. Each key passes through a `SYNC_STAGES`-flop synchronizer, and the busy outputs rise `SYNC_STAGES`+1 clock edges after the pin changes.
- R3: `supply_en` and `clk_on_flag` are both high exactly while a window is running, and low otherwise.
- R4: A window ends on the clock edge that accepts its `TERM_COUNT`-th tick. The busy outputs fall on that edge. Ticks while the counter is idle are not counted.
- R5: At the end of a window, if the selected key reads low on its pin its status bit becomes 1; if it reads high the bit becomes 0. The bit for key k is `key_status[k]`. When the bit changes, `irq` goes to 1 on the same edge.
- R6: A second change on the selected key before the window ends stops the counter. It leaves status and `irq` untouched.
- R7: A change on a different key before the window ends clears the counter and selects the new key. Only that key's status can be updated when the restarted window ends.
- R8: If the selected key's level matches its stored status when the window ends, the status stays the same and no interrupt is raised.
- R9: `irq` is cleared on the edge after `stat_rd` or `irq_clr` is sampled high.
- R10: If an interrupt set and a clear fall on the same edge, `irq` ends up 1.
- R11: Reset (synchronous, active high) clears all status bits, stops the counter and deasserts `irq`.
- R12: If several keys change in the same cycle, the lowest-numbered key among them is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| active_en | input | 1 | High while the device is in an active operating mode |
| dbc_tick | input | 1 | One-cycle debounce clock enable |
| key_n | input | NUM_KEYS | Raw active-low key pins |
| stat_rd | input | 1 | Status-register read strobe, clears the interrupt |
| irq_clr | input | 1 | Clear-interrupt command |
| key_status | output | NUM_KEYS | Debounced pressed status, one bit per key |
| irq | output | 1 | Level interrupt |
| supply_en | output | 1 | Busy flag: supply-output enable |
| clk_on_flag | output | 1 | Busy flag: clock-on request |

## Verification
The bench builds the block with four keys, the default two-stage synchronizer and `TERM_COUNT` set to 12 instead of 8195. With that window length the exact tick on which a window ends can be tested in a few hundred cycles: a window is checked one tick before its end and again at its end. The same setting makes it cheap to show that a restart really clears the counter. The bench also drives abort, restart, simultaneous-change, no-change and set-against-clear sequences, and checks each one against an expected status, interrupt and busy value taken from the requirements.

// File: rtl/mkd_pkg.sv
package mkd_pkg;
  // Width of an index able to address n items, never less than one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of a counter that must hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 0) ? $clog2(n + 1) : 1;
  endfunction
endpackage

// File: rtl/mkd_key_sync.sv
module mkd_key_sync #(
  parameter int unsigned NUM_KEYS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] key_n,
  output logic [NUM_KEYS-1:0] pressed,
  output logic [NUM_KEYS-1:0] key_chg
);
  logic [NUM_KEYS-1:0] pressed_q;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    logic [SYNC_STAGES-1:0] shreg;
    always_ff @(posedge clk) begin
      if (rst) shreg <= '1;
      else     shreg <= {shreg[SYNC_STAGES-2:0], key_n[k]};
    end
    assign pressed[k] = ~shreg[SYNC_STAGES-1];
  end

  // Previous synchronized level, kept up to date regardless of mode so
  // that re-entering an active mode produces no false change.
  always_ff @(posedge clk) begin
    if (rst) pressed_q <= '0;
    else     pressed_q <= pressed;
  end

  assign key_chg = pressed ^ pressed_q;
endmodule

// File: rtl/mkd_pick.sv
module mkd_pick #(
  parameter int unsigned NUM_KEYS = 4,
  localparam int unsigned IW = mkd_pkg::idx_width(NUM_KEYS)
) (
  input  logic [NUM_KEYS-1:0] req,
  output logic                found,
  output logic [IW-1:0]       idx
);
  // Lowest-numbered requester wins: scan downward so the last hit is lowest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mkd_timer.sv
module mkd_timer #(
  parameter int unsigned TERM_COUNT = 8195
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic abort,
  output logic running,
  output logic term
);
  localparam int unsigned CW = mkd_pkg::cnt_width(TERM_COUNT);
  localparam logic [CW-1:0] LAST = CW'(TERM_COUNT - 1);

  logic [CW-1:0] cnt;

  // A change seen in the same cycle as the final tick takes precedence.
  assign term = running && tick && (cnt == LAST) && !start && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (abort || term) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (running && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/multikey_debounce.sv
module multikey_debounce #(
  parameter int unsigned NUM_KEYS    = 4,
  parameter int unsigned TERM_COUNT  = 8195,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                active_en,
  input  logic                dbc_tick,
  input  logic [NUM_KEYS-1:0] key_n,
  input  logic                stat_rd,
  input  logic                irq_clr,
  output logic [NUM_KEYS-1:0] key_status,
  output logic                irq,
  output logic                supply_en,
  output logic                clk_on_flag
);
  localparam int unsigned IW = mkd_pkg::idx_width(NUM_KEYS);

  logic [NUM_KEYS-1:0] pressed;
  logic [NUM_KEYS-1:0] key_chg;
  logic [NUM_KEYS-1:0] chg_act;
  logic [NUM_KEYS-1:0] sel_mask;
  logic [NUM_KEYS-1:0] other_chg;
  logic [IW-1:0]       sel_q;
  logic [IW-1:0]       new_idx;
  logic                new_found;
  logic                running;
  logic                term;
  logic                same_chg;
  logic                abort;
  logic                upd;
  logic                level_sel;
  logic                stat_sel;

  mkd_key_sync #(
    .NUM_KEYS    (NUM_KEYS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .key_n   (key_n),
    .pressed (pressed),
    .key_chg (key_chg)
  );

  assign chg_act = key_chg & {NUM_KEYS{active_en}};

  always_comb begin
    for (int k = 0; k < NUM_KEYS; k++) begin
      sel_mask[k] = running && (sel_q == IW'(k));
    end
  end

  assign other_chg = chg_act & ~sel_mask;
  assign same_chg  = |(chg_act & sel_mask);

  mkd_pick #(
    .NUM_KEYS (NUM_KEYS)
  ) u_pick (
    .req   (other_chg),
    .found (new_found),
    .idx   (new_idx)
  );

  assign abort = !active_en || (same_chg && !new_found);

  mkd_timer #(
    .TERM_COUNT (TERM_COUNT)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (dbc_tick),
    .start   (new_found),
    .abort   (abort),
    .running (running),
    .term    (term)
  );

  always_ff @(posedge clk) begin
    if (rst)            sel_q <= '0;
    else if (new_found) sel_q <= new_idx;
  end

  assign level_sel = |(pressed & sel_mask);
  assign stat_sel  = |(key_status & sel_mask);
  assign upd       = term && (level_sel != stat_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_status <= '0;
      irq        <= 1'b0;
    end else begin
      if (upd) key_status <= (key_status & ~sel_mask) | (pressed & sel_mask);
      if (upd)                     irq <= 1'b1;
      else if (stat_rd || irq_clr) irq <= 1'b0;
    end
  end

  assign supply_en   = running;
  assign clk_on_flag = running;
endmodule

// File: rtl/mkd_checker.sv
module mkd_checker #(
  parameter int unsigned NUM_KEYS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                active_en,
  input logic                stat_rd,
  input logic                irq_clr,
  input logic [NUM_KEYS-1:0] key_status,
  input logic                irq,
  input logic                supply_en,
  input logic                clk_on_flag
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R11
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      reset_state_chk: assert (key_status == '0 && !irq && !supply_en && !clk_on_flag)
        else $error("reset state wrong");
    end
  end

  // R1
  inactive_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !active_en |=> (!supply_en && !clk_on_flag));

  // R4
  irq_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(supply_en) && !supply_en));

  // R9
  clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_rd || irq_clr) && !supply_en) |=> !irq);

  // R5
  one_bit_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_status) |-> ($past(supply_en) && irq &&
      $countones(key_status ^ $past(key_status)) == 1));
endmodule

bind multikey_debounce mkd_checker #(.NUM_KEYS(NUM_KEYS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .active_en   (active_en),
  .stat_rd     (stat_rd),
  .irq_clr     (irq_clr),
  .key_status  (key_status),
  .irq         (irq),
  .supply_en   (supply_en),
  .clk_on_flag (clk_on_flag)
);

// File: tb/multikey_debounce_tb.sv
`timescale 1ns/1ps
module multikey_debounce_tb;
  localparam int unsigned NK = 4;
  localparam int unsigned TC = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          active_en = 1'b0;
  logic          dbc_tick = 1'b0;
  logic [NK-1:0] key_n = '1;
  logic          stat_rd = 1'b0;
  logic          irq_clr = 1'b0;
  logic [NK-1:0] key_status;
  logic          irq, supply_en, clk_on_flag;

  always #10 clk = ~clk;

  multikey_debounce #(.NUM_KEYS(NK), .TERM_COUNT(TC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .active_en(active_en), .dbc_tick(dbc_tick),
    .key_n(key_n), .stat_rd(stat_rd), .irq_clr(irq_clr),
    .key_status(key_status), .irq(irq), .supply_en(supply_en),
    .clk_on_flag(clk_on_flag));

  typedef struct {
    string         tag;
    logic [NK-1:0] st;
    logic          irq;
    logic          busy;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Monitor: compares outputs against queued expectations between edges.
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (key_status !== e.st || irq !== e.irq ||
          supply_en !== e.busy || clk_on_flag !== e.busy) begin
        n_bad++;
        $display("FAIL %s: status=%b irq=%b busy=%b/%b expected status=%b irq=%b busy=%b",
                 e.tag, key_status, irq, supply_en, clk_on_flag, e.st, e.irq, e.busy);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      dbc_tick = 1'b1;
      step(1);
      dbc_tick = 1'b0;
    end
  endtask

  task automatic expect_out(input string tag, input logic [NK-1:0] st,
                            input logic ir, input logic busy);
    exp_t e;
    e.tag = tag; e.st = st; e.irq = ir; e.busy = busy;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    expect_out("R11 reset state", 4'b0000, 0, 0);

    // R1: inactive mode ignores key changes
    key_n[0] = 1'b0;
    step(4);
    expect_out("R1 inactive no start", 4'b0000, 0, 0);
    ticks(TC);
    expect_out("R1 inactive no update", 4'b0000, 0, 0);
    key_n[0] = 1'b1;
    step(4);
    active_en = 1'b1;
    step(2);
    expect_out("R1 re-enable no false change", 4'b0000, 0, 0);

    // R2/R3/R4/R5: press key1, full window
    key_n[1] = 1'b0;
    step(2);
    expect_out("R2 not yet started after two edges", 4'b0000, 0, 0);
    step(1);
    expect_out("R2 R3 busy after sync", 4'b0000, 0, 1);
    ticks(TC - 1);
    expect_out("R4 one tick before end", 4'b0000, 0, 1);
    ticks(1);
    expect_out("R5 press sets status", 4'b0010, 1, 0);
    ticks(3);
    expect_out("R4 idle ticks ignored", 4'b0010, 1, 0);

    // R9: clear by status read
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    expect_out("R9 stat_rd clears irq", 4'b0010, 0, 0);

    // R5: release clears status; R9 clear command
    key_n[1] = 1'b1;
    step(4);
    ticks(TC);
    expect_out("R5 release clears status", 4'b0000, 1, 0);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    expect_out("R9 irq_clr clears irq", 4'b0000, 0, 0);

    // R6: bounce on same key aborts
    key_n[2] = 1'b0;
    step(4);
    ticks(5);
    key_n[2] = 1'b1;
    step(4);
    expect_out("R6 same key aborts", 4'b0000, 0, 0);
    ticks(TC);
    expect_out("R6 no update after abort", 4'b0000, 0, 0);

    // R7: other key restarts and clears the counter
    key_n[0] = 1'b0;
    step(4);
    ticks(8);
    key_n[3] = 1'b0;
    step(4);
    ticks(TC - 1);
    expect_out("R7 counter restarted", 4'b0000, 0, 1);
    ticks(1);
    expect_out("R7 only new key updated", 4'b1000, 1, 0);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;

    // R10: set and clear on the same edge
    key_n[3] = 1'b1;
    step(4);
    ticks(TC - 1);
    dbc_tick = 1'b1; stat_rd = 1'b1;
    step(1);
    dbc_tick = 1'b0; stat_rd = 1'b0;
    expect_out("R10 set wins over clear", 4'b0000, 1, 0);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;

    // R12: simultaneous changes pick lowest index (key1 over key2)
    key_n[1] = 1'b0; key_n[2] = 1'b0;
    step(4);
    ticks(TC);
    expect_out("R12 lowest index selected", 4'b0010, 1, 0);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;

    // R8: window ends with level equal to stored status
    key_n[1] = 1'b1;
    step(4);
    ticks(2);
    key_n[0] = 1'b1;
    step(4);
    key_n[1] = 1'b0;
    step(4);
    ticks(TC);
    expect_out("R8 no change no irq", 4'b0010, 0, 0);

    // R1: leaving active mode abandons a running window
    key_n[2] = 1'b1;
    step(4);
    ticks(3);
    expect_out("R1 running before exit", 4'b0010, 0, 1);
    active_en = 1'b0;
    step(1);
    expect_out("R1 exit stops counter", 4'b0010, 0, 0);
    active_en = 1'b1;
    ticks(TC);
    expect_out("R1 no update after exit", 4'b0010, 0, 0);

    step(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule